// File: doc/BRIEF.md
# External Interrupt Request Latch

This block is the external interrupt front end of a small 8-bit controller. It merges one active-low interrupt pin and a group of four active-high port pins into one request line to the CPU. All pins are brought into the clock domain through a synchronizer chain. The synchronized values are merged into one internal "active" signal, which feeds an edge detector and a pending flag. The CPU sees the flag as its request and clears it with a one-cycle acknowledge strobe.

A static configuration input picks the trigger mode. In edge mode, only a transition of the merged signal into its active state records a request. In edge-plus-level mode, a merged signal that stays active also keeps recording requests, which allows several open-drain sources to share the pin. A second static configuration input allows the port group to take part at all. A run-time control bit, written through a simple write strobe, then switches the four pins on or off together.

There is no data stream here. Every pin is a plain control or status signal, with no valid/ready handshake and no back-pressure.

Top module: `ext_irq_frontend`

## Requirements
- R1: After a synchronous reset, `pending`, `cpu_req` and `grp_en` are all 0.
- R2: In edge mode (`cfg_level`=0), a falling edge on `irq_n_pin` sets `pending`. This happens at the third rising clock edge after the pin changes: two synchronizer stages, then the flag.
- R3: In edge mode, a pin held low gives exactly one request. After an acknowledge, `pending` stays 0 until the merged signal has gone inactive and become active again.
- R4: In edge-plus-level mode (`cfg_level`=1), an active merged signal sets `pending`. If the signal is still active when `ack` clears the flag, the flag is 0 for one cycle and is set again at the next clock.
- R5: Port pins affect nothing unless both `cfg_port_join`=1 and `grp_en`=1. Otherwise a port pin that is high or rising leaves `pending` at 0.
- R6: When the group takes part, a port pin counts as active when high. It triggers on a rising edge in edge mode, and on a rising edge or a high level in edge-plus-level mode.
- R7: The merged signal is true when `irq_n_pin` is low OR any joined port pin is high. In edge mode, a second source going active while another source already holds the signal active does not make a new request.
- R8: `ack` clears `pending` at the next clock. If a fresh edge is detected in the same cycle as `ack`, `pending` stays 1 and that request is not lost.
- R9: `cpu_req` equals `pending` in every cycle.
- R10: A cycle with `ctl_wr`=1 loads `ctl_wdata` into `grp_en`, and `grp_en` reads back the stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_level | input | 1 | Trigger mode: 0 edge only, 1 edge plus level |
| cfg_port_join | input | 1 | Static permission for the port group to join the interrupt |
| ctl_wr | input | 1 | Write strobe for the group enable bit |
| ctl_wdata | input | 1 | Value written to the group enable bit |
| irq_n_pin | input | 1 | Active-low interrupt pin, asynchronous |
| port_pins | input | 4 | Active-high port pins, asynchronous |
| ack | input | 1 | One-cycle acknowledge from the CPU, clears the pending flag |
| grp_en | output | 1 | Group enable bit, read back |
| pending | output | 1 | Pending flag for the status register |
| cpu_req | output | 1 | Interrupt request to the CPU |

## Verification
The bench holds the interrupt pin low across an acknowledge in both modes. An edge-only design that re-armed on level would request again, and a level design that missed the re-set would go quiet. The bench also lets an acknowledge land in the same cycle as a fresh edge, which a design that gives clear priority to the strobe would drop. It raises port pins while the group is masked, either by the static permission or by the run-time bit, and also while the pin is already low. Either case shows a request where none is due: a leak through the mask, or an edge taken on one source instead of the merged signal.

// File: rtl/irq_fe_pkg.sv
package irq_fe_pkg;
  typedef enum logic {
    TRIG_EDGE       = 1'b0,
    TRIG_EDGE_LEVEL = 1'b1
  } trig_mode_e;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int          W       = 5,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      for (int i = STAGES - 1; i > 0; i--) stg[i] <= stg[i-1];
      stg[0] <= d;
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/irq_detect.sv
module irq_detect #(
  parameter int PORT_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pin_n_s,
  input  logic [PORT_W-1:0] port_s,
  input  logic              port_join,
  input  logic              grp_en,
  output logic              act,
  output logic              rise_evt
);
  logic act_q;
  logic port_act;

  assign port_act = port_join & grp_en & (|port_s);
  assign act      = ~pin_n_s | port_act;
  assign rise_evt = act & ~act_q;

  always_ff @(posedge clk) begin
    if (rst) act_q <= 1'b0;
    else     act_q <= act;
  end

  // R7: an event needs the merged signal to have been inactive one cycle back
  a_r7_event_needs_idle: assert property (@(posedge clk) disable iff (rst)
    rise_evt |-> !act_q);
  // R5: masked port pins alone never make the merged signal active
  a_r5_mask_blocks_port: assert property (@(posedge clk) disable iff (rst)
    (pin_n_s && !(port_join && grp_en)) |-> !act);
endmodule

// File: rtl/irq_pend.sv
module irq_pend
  import irq_fe_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  trig_mode_e mode,
  input  logic       act,
  input  logic       rise_evt,
  input  logic       ack,
  output logic       pend
);
  logic pend_q;
  logic hold_set;

  assign hold_set = (mode == TRIG_EDGE_LEVEL) & act;

  always_ff @(posedge clk) begin
    if (rst)      pend_q <= 1'b0;
    else if (ack) pend_q <= rise_evt;
    else          pend_q <= pend_q | rise_evt | hold_set;
  end

  assign pend = pend_q;

  a_r2_event_sets: assert property (@(posedge clk) disable iff (rst)
    rise_evt |=> pend_q);
  a_r8_ack_clears: assert property (@(posedge clk) disable iff (rst)
    (ack && !rise_evt) |=> !pend_q);
  a_r3_edge_mode_idle: assert property (@(posedge clk) disable iff (rst)
    (mode == TRIG_EDGE && !pend_q && !rise_evt) |=> !pend_q);
  a_r4_level_resets: assert property (@(posedge clk) disable iff (rst)
    (mode == TRIG_EDGE_LEVEL && act && !ack) |=> pend_q);
endmodule

// File: rtl/ext_irq_frontend.sv
module ext_irq_frontend
  import irq_fe_pkg::*;
#(
  parameter int PORT_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_level,
  input  logic              cfg_port_join,
  input  logic              ctl_wr,
  input  logic              ctl_wdata,
  input  logic              irq_n_pin,
  input  logic [PORT_W-1:0] port_pins,
  input  logic              ack,
  output logic              grp_en,
  output logic              pending,
  output logic              cpu_req
);
  localparam int IN_W = PORT_W + 1;
  localparam logic [IN_W-1:0] IN_IDLE = {{PORT_W{1'b0}}, 1'b1};

  logic [IN_W-1:0] raw_in, syn_in;
  logic            grp_en_q;
  logic            act, rise_evt, pend;
  trig_mode_e      mode;

  assign raw_in = {port_pins, irq_n_pin};
  assign mode   = trig_mode_e'(cfg_level);

  always_ff @(posedge clk) begin
    if (rst)         grp_en_q <= 1'b0;
    else if (ctl_wr) grp_en_q <= ctl_wdata;
  end

  irq_sync #(.W(IN_W), .STAGES(SYNC_STAGES), .RST_VAL(IN_IDLE)) u_sync (
    .clk(clk), .rst(rst), .d(raw_in), .q(syn_in)
  );

  irq_detect #(.PORT_W(PORT_W)) u_det (
    .clk(clk), .rst(rst),
    .pin_n_s(syn_in[0]), .port_s(syn_in[IN_W-1:1]),
    .port_join(cfg_port_join), .grp_en(grp_en_q),
    .act(act), .rise_evt(rise_evt)
  );

  irq_pend u_pend (
    .clk(clk), .rst(rst), .mode(mode),
    .act(act), .rise_evt(rise_evt), .ack(ack), .pend(pend)
  );

  assign grp_en  = grp_en_q;
  assign pending = pend;
  assign cpu_req = pend;

  a_r10_enable_write: assert property (@(posedge clk) disable iff (rst)
    ctl_wr |=> (grp_en == $past(ctl_wdata)));
  a_r10_enable_hold: assert property (@(posedge clk) disable iff (rst)
    !ctl_wr |=> $stable(grp_en));
endmodule

// File: tb/tb_ext_irq_frontend.sv
`timescale 1ns/1ps
module tb_ext_irq_frontend;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_level = 1'b0, cfg_port_join = 1'b0;
  logic ctl_wr = 1'b0, ctl_wdata = 1'b0;
  logic irq_n_pin = 1'b1;
  logic [3:0] port_pins = 4'b0;
  logic ack = 1'b0;
  logic grp_en, pending, cpu_req;

  int total = 0, bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ext_irq_frontend dut (
    .clk(clk), .rst(rst), .cfg_level(cfg_level), .cfg_port_join(cfg_port_join),
    .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .irq_n_pin(irq_n_pin),
    .port_pins(port_pins), .ack(ack), .grp_en(grp_en), .pending(pending),
    .cpu_req(cpu_req)
  );

  // behavioural reference: inputs seen two clocks late, merged, edge + level
  logic [4:0] hist[$];
  logic [4:0] seen;
  logic m_act, m_rise;
  logic m_prev = 1'b0, m_pend = 1'b0, m_en = 1'b0;

  always @(posedge clk) begin
    if (rst) begin
      hist.delete();
      m_prev <= 1'b0; m_pend <= 1'b0; m_en <= 1'b0;
    end else begin
      seen   = (hist.size() >= 2) ? hist[hist.size()-2] : 5'b00001;
      m_act  = !seen[0] || (cfg_port_join && m_en && (seen[4:1] != 4'b0));
      m_rise = m_act && !m_prev;
      m_prev <= m_act;
      if (ack) m_pend <= m_rise;
      else     m_pend <= m_pend || m_rise || (cfg_level && m_act);
      if (ctl_wr) m_en <= ctl_wdata;
      hist.push_back({port_pins, irq_n_pin});
      if (hist.size() > 4) void'(hist.pop_front());
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      total++;
      if (pending !== m_pend || cpu_req !== m_pend || grp_en !== m_en) begin
        bad++;
        $display("FAIL R9 model: pending=%b cpu_req=%b grp_en=%b expected %b/%b/%b",
                 pending, cpu_req, grp_en, m_pend, m_pend, m_en);
      end
    end
  end

  task automatic chk(input string tag, input logic act_v, input logic exp_v);
    total++;
    if (act_v !== exp_v) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b", tag, act_v, exp_v);
    end
  endtask

  task automatic wt(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_ack();
    ack = 1'b1; wt(1); ack = 1'b0;
  endtask

  initial begin
    #(8 * 20000);
    bad++; total++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wt(3);
    rst = 1'b0;
    // R1 reset state
    chk("R1 pending", pending, 1'b0);
    chk("R1 cpu_req", cpu_req, 1'b0);
    chk("R1 grp_en", grp_en, 1'b0);

    // R2 edge mode latency
    irq_n_pin = 1'b0;
    wt(2); chk("R2 not yet", pending, 1'b0);
    wt(1); chk("R2 set", pending, 1'b1);
    chk("R9 req", cpu_req, 1'b1);
    // R3 held low: one request only
    wt(5); pulse_ack(); wt(5);
    chk("R3 held low no repeat", pending, 1'b0);
    irq_n_pin = 1'b1; wt(4);
    irq_n_pin = 1'b0; wt(3);
    chk("R3 fresh edge", pending, 1'b1);
    pulse_ack(); irq_n_pin = 1'b1; wt(4);

    // R4 level mode
    cfg_level = 1'b1;
    irq_n_pin = 1'b0; wt(3);
    chk("R4 level set", pending, 1'b1);
    ack = 1'b1; wt(1); ack = 1'b0;
    chk("R4 cleared one cycle", pending, 1'b0);
    wt(1); chk("R4 set again", pending, 1'b1);
    irq_n_pin = 1'b1; wt(3); pulse_ack(); wt(3);
    chk("R4 released stays clear", pending, 1'b0);

    // R5 port masked by static permission
    cfg_level = 1'b0;
    ctl_wdata = 1'b1; ctl_wr = 1'b1; wt(1); ctl_wr = 1'b0;
    chk("R10 enable written", grp_en, 1'b1);
    port_pins = 4'b0100; wt(5);
    chk("R5 join off ignored", pending, 1'b0);
    port_pins = 4'b0000; wt(2);
    // R5 masked by run-time bit
    cfg_port_join = 1'b1;
    ctl_wdata = 1'b0; ctl_wr = 1'b1; wt(1); ctl_wr = 1'b0;
    chk("R10 enable cleared", grp_en, 1'b0);
    port_pins = 4'b1000; wt(5);
    chk("R5 group off ignored", pending, 1'b0);
    port_pins = 4'b0000; wt(2);
    ctl_wdata = 1'b1; ctl_wr = 1'b1; wt(1); ctl_wr = 1'b0;
    wt(3);

    // R6 rising edge on a port pin
    port_pins = 4'b0001; wt(3);
    chk("R6 port rise", pending, 1'b1);
    pulse_ack(); wt(4);
    chk("R6 edge mode single", pending, 1'b0);
    port_pins = 4'b0000; wt(4);

    // R6 high level in level mode
    cfg_level = 1'b1;
    port_pins = 4'b0010; wt(3);
    pulse_ack(); wt(1);
    chk("R6 port level re-set", pending, 1'b1);
    port_pins = 4'b0000; wt(3); pulse_ack(); wt(2);
    cfg_level = 1'b0;

    // R8 ack coincides with a fresh edge
    port_pins = 4'b0001; wt(4);
    chk("R8 setup", pending, 1'b1);
    port_pins = 4'b0000; wt(4);
    irq_n_pin = 1'b0; wt(2);
    ack = 1'b1; wt(1); ack = 1'b0;
    chk("R8 edge survives ack", pending, 1'b1);
    pulse_ack(); wt(1);
    chk("R8 plain ack clears", pending, 1'b0);

    // R7 second source while merged signal already active
    port_pins = 4'b1111; wt(5);
    chk("R7 no new edge", pending, 1'b0);
    irq_n_pin = 1'b1; wt(5);
    chk("R7 port still holds", pending, 1'b0);
    port_pins = 4'b0000; wt(4);
    irq_n_pin = 1'b0; wt(3);
    chk("R7 fresh after idle", pending, 1'b1);

    // R1 reset mid-run
    rst = 1'b1; wt(2); rst = 1'b0;
    chk("R1 reset pending", pending, 1'b0);
    chk("R1 reset grp_en", grp_en, 1'b0);
    irq_n_pin = 1'b1; wt(4);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule